// File: doc/BRIEF.md
# Byte ALU with flag register

This unit carries out the register-to-register arithmetic and logic operations of a small 8-bit interpreter-style CPU. Each cycle it takes two byte operands, X and Y, and a 4-bit operation selector. The selector is the low nibble of the register-pair instruction group. The unit returns the byte to be written back into register X and a one-bit value for the flag register. It also returns a separate write-enable for each of the two, so that the register file can decide what happens when X is the flag register itself. In that case the flag write must win.

The supported operations are copy, OR, AND, XOR, add with carry-out, subtract, reverse subtract (Y minus X), and a one-bit shift in either direction. For subtraction the flag means "no borrow": it is 1 when the minuend is greater than or equal to the subtrahend. For a shift, the flag receives the bit that is pushed out. A selector that names no operation raises an illegal-operation output, and the unit then enables neither write.

The datapath is combinational. An output register stage is present by default and can be removed with a parameter.

Top module: `byte_alu`

## Requirements
- R1: Selector 0 gives result Y, selector 1 gives X OR Y, selector 2 gives X AND Y and selector 3 gives X XOR Y. For these, the result write-enable is 1, the flag write-enable is 0 and the flag value is 0.
- R2: Selector 4 gives result (X + Y) mod 256. The flag is 1 exactly when X + Y > 255. Both write-enables are 1.
- R3: Selector 5 gives result (X − Y) mod 256. The flag is 1 when X ≥ Y, which includes equal operands, and 0 when a borrow occurs. Both write-enables are 1.
- R4: Selector 7 gives result (Y − X) mod 256. The flag is 1 when Y ≥ X and 0 otherwise. Both write-enables are 1.
- R5: Selector 6 gives result X shifted right by one with a 0 shifted in at the top. The flag equals bit 0 of X. Both write-enables are 1.
- R6: Selector 14 (hex E) gives result X shifted left by one with a 0 shifted in at the bottom. The flag equals bit 7 of X. Both write-enables are 1.
- R7: Selectors 8 to 13 and 15 set the illegal-operation output to 1. Both write-enables are 0, and the result and flag values are 0.
- R8: When in_valid is 0, every output is 0, whatever the selector and operands are.
- R9: With the default output register, each set of outputs appears one clock after its inputs are presented. A synchronous active-high reset clears every output to 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies the selector and operands |
| op_sel | input | 4 | Operation selector |
| x_val | input | 8 | Operand X (also the destination register's old value) |
| y_val | input | 8 | Operand Y |
| res_data | output | 8 | Result for register X, 0 when not enabled |
| res_we | output | 1 | Result write-enable |
| flag_data | output | 1 | Value for the flag register, 0 when not enabled |
| flag_we | output | 1 | Flag write-enable |
| illegal_op | output | 1 | Selector names no operation |

## Verification
Two subtraction cases are the hardest to reach. The first is equal operands: the carry of the shared adder must read as "no borrow". The second is the reverse direction, where the operand roles swap inside the carry chain. Random operands almost never produce either case. The stimulus therefore applies them directly: equal bytes, a minuend one below the subtrahend, and the 0x00/0xFF extremes in both operand orders. It also applies shifts whose outgoing bit is set. A random sweep over all sixteen selectors follows, with in_valid dropped and reset pulsed at random points, and the reference model is compared against the outputs on every clock.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

    parameter int DATA_W = 8;
    parameter int SEL_W  = 4;

    typedef enum logic [SEL_W-1:0] {
        SEL_MOVE = 4'h0,
        SEL_OR   = 4'h1,
        SEL_AND  = 4'h2,
        SEL_XOR  = 4'h3,
        SEL_ADD  = 4'h4,
        SEL_SUB  = 4'h5,
        SEL_SHR  = 4'h6,
        SEL_RSUB = 4'h7,
        SEL_SHL  = 4'hE
    } alu_sel_e;

    typedef enum logic [1:0] {
        UNIT_LOGIC,
        UNIT_ARITH,
        UNIT_SHIFT,
        UNIT_NONE
    } alu_unit_e;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              flag;
    } unit_out_t;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              res_we;
        logic              flag;
        logic              flag_we;
        logic              illegal;
    } alu_out_t;

    function automatic alu_unit_e unit_of(input logic [SEL_W-1:0] s);
        case (s)
            SEL_MOVE, SEL_OR, SEL_AND, SEL_XOR: return UNIT_LOGIC;
            SEL_ADD, SEL_SUB, SEL_RSUB:         return UNIT_ARITH;
            SEL_SHR, SEL_SHL:                   return UNIT_SHIFT;
            default:                            return UNIT_NONE;
        endcase
    endfunction

endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import byte_alu_pkg::*;
(
    input  logic             valid,
    input  logic [SEL_W-1:0] sel,
    output alu_unit_e        unit,
    output logic             res_en,
    output logic             flag_en,
    output logic             bad_sel
);
    always_comb begin
        unit    = unit_of(sel);
        res_en  = 1'b0;
        flag_en = 1'b0;
        bad_sel = 1'b0;
        if (valid) begin
            case (unit)
                UNIT_LOGIC: res_en = 1'b1;
                UNIT_ARITH,
                UNIT_SHIFT: begin
                    res_en  = 1'b1;
                    flag_en = 1'b1;
                end
                default:    bad_sel = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import byte_alu_pkg::*;
(
    input  logic [1:0]        fn,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    always_comb begin
        case (fn)
            2'd0:    y = b;
            2'd1:    y = a | b;
            2'd2:    y = a & b;
            default: y = a ^ b;
        endcase
    end
endmodule

// File: rtl/alu_arith.sv
module alu_arith
    import byte_alu_pkg::*;
(
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output unit_out_t         y
);
    localparam int SUM_W = DATA_W + 1;

    logic [DATA_W-1:0] lhs;
    logic [DATA_W-1:0] rhs;
    logic              cin;
    logic [SUM_W-1:0]  sum;

    // One carry chain serves all three operations; subtraction adds the
    // inverted subtrahend plus one, so carry-out means "no borrow".
    always_comb begin
        case (sel)
            SEL_SUB: begin
                lhs = a;
                rhs = ~b;
                cin = 1'b1;
            end
            SEL_RSUB: begin
                lhs = b;
                rhs = ~a;
                cin = 1'b1;
            end
            default: begin
                lhs = a;
                rhs = b;
                cin = 1'b0;
            end
        endcase
        sum     = {1'b0, lhs} + {1'b0, rhs} + {{DATA_W{1'b0}}, cin};
        y.value = sum[DATA_W-1:0];
        y.flag  = sum[SUM_W-1];
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
    import byte_alu_pkg::*;
(
    input  logic              to_left,
    input  logic [DATA_W-1:0] a,
    output unit_out_t         y
);
    always_comb begin
        if (to_left) begin
            y.value = {a[DATA_W-2:0], 1'b0};
            y.flag  = a[DATA_W-1];
        end else begin
            y.value = {1'b0, a[DATA_W-1:1]};
            y.flag  = a[0];
        end
    end
endmodule

// File: rtl/byte_alu.sv
module byte_alu
    import byte_alu_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [SEL_W-1:0]  op_sel,
    input  logic [DATA_W-1:0] x_val,
    input  logic [DATA_W-1:0] y_val,
    output logic [DATA_W-1:0] res_data,
    output logic              res_we,
    output logic              flag_data,
    output logic              flag_we,
    output logic              illegal_op
);
    localparam int SHIFT_DIR_BIT = SEL_W - 1;

    alu_unit_e         unit;
    logic              res_en;
    logic              flag_en;
    logic              bad_sel;
    logic [DATA_W-1:0] logic_y;
    unit_out_t         arith_y;
    unit_out_t         shift_y;
    alu_out_t          comb_o;
    alu_out_t          out_q;

    alu_decode u_dec (
        .valid   (in_valid),
        .sel     (op_sel),
        .unit    (unit),
        .res_en  (res_en),
        .flag_en (flag_en),
        .bad_sel (bad_sel)
    );

    alu_logic u_logic (
        .fn (op_sel[1:0]),
        .a  (x_val),
        .b  (y_val),
        .y  (logic_y)
    );

    alu_arith u_arith (
        .sel (op_sel),
        .a   (x_val),
        .b   (y_val),
        .y   (arith_y)
    );

    alu_shift u_shift (
        .to_left (op_sel[SHIFT_DIR_BIT]),
        .a       (x_val),
        .y       (shift_y)
    );

    always_comb begin
        comb_o         = '0;
        comb_o.res_we  = res_en;
        comb_o.flag_we = flag_en;
        comb_o.illegal = bad_sel;
        case (unit)
            UNIT_LOGIC: comb_o.res = logic_y;
            UNIT_ARITH: begin
                comb_o.res  = arith_y.value;
                comb_o.flag = arith_y.flag;
            end
            UNIT_SHIFT: begin
                comb_o.res  = shift_y.value;
                comb_o.flag = shift_y.flag;
            end
            default: ;
        endcase
        if (!res_en)  comb_o.res  = '0;
        if (!flag_en) comb_o.flag = 1'b0;
    end

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) out_q <= '0;
                else     out_q <= comb_o;
            end
        end else begin : g_comb
            assign out_q = comb_o;
        end
    endgenerate

    assign res_data   = out_q.res;
    assign res_we     = out_q.res_we;
    assign flag_data  = out_q.flag;
    assign flag_we    = out_q.flag_we;
    assign illegal_op = out_q.illegal;
endmodule

// File: rtl/byte_alu_chk.sv
module byte_alu_chk
    import byte_alu_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [SEL_W-1:0]  op_sel,
    input logic [DATA_W-1:0] x_val,
    input logic [DATA_W-1:0] y_val,
    input logic [DATA_W-1:0] res_data,
    input logic              res_we,
    input logic              flag_data,
    input logic              flag_we,
    input logic              illegal_op
);
    generate
        if (OUT_REG) begin : g_seq
            // R7
            illegal_no_write_chk: assert property (@(posedge clk) disable iff (rst)
                illegal_op |-> (!res_we && !flag_we));

            // R8
            idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> (!res_we && !flag_we && !illegal_op));

            // R1
            logic_keeps_flag_chk: assert property (@(posedge clk) disable iff (rst)
                (in_valid && op_sel < 4'h4) |=> (res_we && !flag_we && !illegal_op));

            // R2
            add_carry_chk: assert property (@(posedge clk) disable iff (rst)
                (in_valid && op_sel == 4'h4) |=>
                    (flag_we && flag_data == ((9'($past(x_val)) + 9'($past(y_val))) > 9'd255)));

            // R3
            sub_noborrow_chk: assert property (@(posedge clk) disable iff (rst)
                (in_valid && op_sel == 4'h5) |=>
                    (flag_we && flag_data == ($past(x_val) >= $past(y_val))));

            // R4
            rsub_noborrow_chk: assert property (@(posedge clk) disable iff (rst)
                (in_valid && op_sel == 4'h7) |=>
                    (flag_we && flag_data == ($past(y_val) >= $past(x_val))));

            // R6
            shl_outbit_chk: assert property (@(posedge clk) disable iff (rst)
                (in_valid && op_sel == 4'hE) |=> (flag_data == $past(x_val[DATA_W-1])));
        end else begin : g_comb
            // R7
            always_comb begin
                if (!rst) begin
                    illegal_no_write_chk: assert (!(illegal_op && (res_we || flag_we)));
                end
            end
        end
    endgenerate
endmodule

bind byte_alu byte_alu_chk #(.OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/test_byte_alu.sv
module test_byte_alu;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [3:0] op_sel = 4'h0;
    logic [7:0] x_val = 8'h00;
    logic [7:0] y_val = 8'h00;
    logic [7:0] res_data;
    logic       res_we;
    logic       flag_data;
    logic       flag_we;
    logic       illegal_op;

    int n_checks = 0;
    int n_fails  = 0;

    typedef struct {
        int    res;
        int    rwe;
        int    flag;
        int    fwe;
        int    ill;
        string tag;
    } exp_t;

    exp_t pending[$];

    byte_alu i_byte_alu (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .op_sel     (op_sel),
        .x_val      (x_val),
        .y_val      (y_val),
        .res_data   (res_data),
        .res_we     (res_we),
        .flag_data  (flag_data),
        .flag_we    (flag_we),
        .illegal_op (illegal_op)
    );

    always #2 clk = ~clk;

    function automatic exp_t model(bit r, bit v, int s, int x, int y);
        exp_t e = '{0, 0, 0, 0, 0, "R9"};
        if (r) return e;
        e.tag = "R8";
        if (!v) return e;
        e.rwe = 1;
        e.fwe = 1;
        case (s)
            0: begin e.res = y;     e.fwe = 0; e.tag = "R1"; end
            1: begin e.res = x | y; e.fwe = 0; e.tag = "R1"; end
            2: begin e.res = x & y; e.fwe = 0; e.tag = "R1"; end
            3: begin e.res = x ^ y; e.fwe = 0; e.tag = "R1"; end
            4: begin
                e.res = (x + y) % 256; e.flag = (x + y > 255) ? 1 : 0; e.tag = "R2";
            end
            5: begin
                e.res = (x - y + 256) % 256; e.flag = (x >= y) ? 1 : 0; e.tag = "R3";
            end
            7: begin
                e.res = (y - x + 256) % 256; e.flag = (y >= x) ? 1 : 0; e.tag = "R4";
            end
            6: begin
                e.res = x / 2; e.flag = x % 2; e.tag = "R5";
            end
            14: begin
                e.res = (x * 2) % 256; e.flag = x / 128; e.tag = "R6";
            end
            default: begin
                e.rwe = 0; e.fwe = 0; e.ill = 1; e.tag = "R7";
            end
        endcase
        return e;
    endfunction

    task automatic compare();
        exp_t e;
        if (pending.size() == 0) return;
        e = pending.pop_front();
        n_checks++;
        if (int'(res_data) != e.res || int'(res_we) != e.rwe || int'(flag_data) != e.flag ||
            int'(flag_we) != e.fwe || int'(illegal_op) != e.ill) begin
            n_fails++;
            $display("FAIL %s: got res=%02h rwe=%0d flag=%0d fwe=%0d ill=%0d, expected res=%02h rwe=%0d flag=%0d fwe=%0d ill=%0d",
                     e.tag, res_data, res_we, flag_data, flag_we, illegal_op,
                     e.res, e.rwe, e.flag, e.fwe, e.ill);
        end
    endtask

    task automatic step(bit r, bit v, int s, int x, int y);
        @(negedge clk);
        compare();
        rst      = r;
        in_valid = v;
        op_sel   = 4'(s);
        x_val    = 8'(x);
        y_val    = 8'(y);
        pending.push_back(model(r, v, s, x, y));
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R9: watchdog expired, got no finish, expected finish");
        summary();
    end

    initial begin
        // R9 reset state
        step(1, 1, 4, 8'hFF, 8'hFF);
        step(1, 0, 0, 0, 0);
        // R1 copy and bitwise
        step(0, 1, 0, 8'h12, 8'hA5);
        step(0, 1, 1, 8'h0F, 8'hF0);
        step(0, 1, 2, 8'h3C, 8'hF3);
        step(0, 1, 3, 8'hFF, 8'h5A);
        // R2 add carry boundaries
        step(0, 1, 4, 8'hFF, 8'h01);
        step(0, 1, 4, 8'h80, 8'h80);
        step(0, 1, 4, 8'h7F, 8'h80);
        step(0, 1, 4, 8'h00, 8'h00);
        // R3 subtract: equal, one below, extremes
        step(0, 1, 5, 8'h55, 8'h55);
        step(0, 1, 5, 8'h00, 8'h01);
        step(0, 1, 5, 8'hFF, 8'h00);
        step(0, 1, 5, 8'h00, 8'hFF);
        // R4 reverse subtract
        step(0, 1, 7, 8'h10, 8'h20);
        step(0, 1, 7, 8'h20, 8'h10);
        step(0, 1, 7, 8'hAA, 8'hAA);
        step(0, 1, 7, 8'hFF, 8'h00);
        // R5 shift right
        step(0, 1, 6, 8'h01, 8'h00);
        step(0, 1, 6, 8'hFE, 8'hFF);
        // R6 shift left
        step(0, 1, 14, 8'h80, 8'h00);
        step(0, 1, 14, 8'h7F, 8'h00);
        // R7 every illegal selector
        for (int s = 8; s < 16; s++) begin
            if (s != 14) step(0, 1, s, 8'hFF, 8'hFF);
        end
        // R8 idle with a selector that would write
        step(0, 0, 4, 8'hFF, 8'h01);
        step(0, 0, 9, 8'hFF, 8'h01);
        // R9 reset in mid-stream
        step(1, 1, 5, 8'h33, 8'h11);
        // sweep
        for (int i = 0; i < 600; i++) begin
            step(($urandom % 40) == 0, ($urandom % 8) != 0, int'($urandom % 16),
                 int'($urandom % 256), int'($urandom % 256));
        end
        step(0, 0, 0, 0, 0);
        @(negedge clk);
        compare();
        summary();
    end
endmodule